// File: doc/BRIEF.md
# Profile tuning word update controller

This block keeps a small bank of frequency tuning word profiles and presents one of them, the active word, to a downstream frequency synthesizer. A simple write bus (address, data, strobe) fills the profiles; the bus decoder in front of it is not part of the block. A two-bit profile select input picks which stored profile is the candidate for the active word.

The block has two operating modes. In direct mode the active word follows the selected profile on its own. In single-tone mode the active word is frozen. It changes only when an external, asynchronous frequency-update input rises. That edge copies the selected profile into the active register and fires a one-cycle restart pulse, so the synthesizer phase starts in step with the external event. The update input and the select inputs each pass through a two-flop synchronizer before they are used.

Top module: `ftw_profile_ctrl`

## Requirements
- R1: While `rst_ni` is low, all profiles and the active word are cleared, so `ftw_o` reads 0 and `restart_o` reads 0.
- R2: A clock edge that sees `wr_en_i` high stores `wr_data_i` into the profile numbered `wr_addr_i`. Other profiles are left unchanged.
- R3: In single-tone mode (`single_tone_i`=1), a write to the selected profile does not change `ftw_o` until the next update pulse. The next update pulse then loads the new value.
- R4: In single-tone mode, a change on `prof_sel_i` alone does not change `ftw_o` and does not assert `restart_o`.
- R5: In single-tone mode, when `update_i` rises, `ftw_o` takes the selected profile and `restart_o` goes high, both on the third rising clock edge that sees `update_i` high. Until then `ftw_o` keeps its old value.
- R6: `restart_o` is high for exactly one cycle for each rising edge of `update_i`. Holding `update_i` high produces no further pulses.
- R7: In direct mode (`single_tone_i`=0), `ftw_o` shows the newly selected profile from the third rising edge after `prof_sel_i` changes. In this mode `update_i` has no effect on either output, and `restart_o` stays 0.
- R8: In direct mode, a write to the currently selected profile appears on `ftw_o` one clock edge after the edge that stores it.
- R9: Profile n (0 to 3) is the one written with `wr_addr_i`=n and the one chosen with `prof_sel_i`=n. This holds for both direct selection and loads by update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| single_tone_i | input | 1 | 1 = single-tone mode (update-gated), 0 = direct mode |
| wr_en_i | input | 1 | Profile write strobe |
| wr_addr_i | input | 2 | Profile number to write |
| wr_data_i | input | 32 | Tuning word to write |
| prof_sel_i | input | 2 | Asynchronous profile select |
| update_i | input | 1 | Asynchronous frequency-update input |
| ftw_o | output | 32 | Active tuning word |
| restart_o | output | 1 | One-cycle synthesizer phase restart |

## Verification
Signals from `update_i` and `prof_sel_i` cross two synchronizer flops and then the active register. Their results are therefore due on the third rising edge after the input changes. A write to the selected profile in direct mode is due on the second edge, and `restart_o` lasts exactly one cycle. The bench drives inputs on falling edges and samples on falling edges. It checks that the old value still holds after two edges and that the new value appears after the third edge, so both an early load and a late load are caught. Hold intervals are observed over several cycles.

// File: rtl/ftw_pkg.sv
package ftw_pkg;
  localparam int unsigned PROF_NUM   = 4;
  localparam int unsigned FTW_WIDTH  = 32;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/ftw_sync.sv
module ftw_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ftw_edge.sv
module ftw_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~prev_q;

  p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  p_pulse_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && $past(lvl_i)) |-> !pulse_o);
endmodule

// File: rtl/ftw_bank.sv
module ftw_bank #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32,
  localparam int unsigned AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_sel_i,
  output logic [W-1:0]  rd_word_o
);
  logic [W-1:0] prof_q [N];

  for (genvar p = 0; p < N; p++) begin : g_prof
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  prof_q[p] <= '0;
      else if (hit) prof_q[p] <= wr_data_i;
    end
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel_i == AW'(i)) rd_word_o = prof_q[i];
    end
  end

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i <= AW'(N-1)) |=> prof_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/ftw_active.sv
module ftw_active #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         single_tone_i,
  input  logic         upd_pulse_i,
  input  logic [W-1:0] sel_word_i,
  output logic [W-1:0] ftw_o,
  output logic         restart_o
);
  logic load;

  // single-tone: load only on update; direct: follow every cycle
  assign load = single_tone_i ? upd_pulse_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_o     <= '0;
      restart_o <= 1'b0;
    end else begin
      if (load) ftw_o <= sel_word_i;
      restart_o <= single_tone_i & upd_pulse_i;
    end
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_tone_i && $past(single_tone_i) && !restart_o) |-> $stable(ftw_o));
  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> ftw_o == $past(sel_word_i));
  p_restart_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(single_tone_i) |-> !restart_o);
endmodule

// File: rtl/ftw_profile_ctrl.sv
module ftw_profile_ctrl
  import ftw_pkg::*;
#(
  parameter int unsigned NPROF = PROF_NUM,
  parameter int unsigned FTW_W = FTW_WIDTH,
  parameter int unsigned SYNC_N = SYNC_DEPTH,
  localparam int unsigned SEL_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             single_tone_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_addr_i,
  input  logic [FTW_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] prof_sel_i,
  input  logic             update_i,
  output logic [FTW_W-1:0] ftw_o,
  output logic             restart_o
);
  logic             upd_lvl;
  logic             upd_pulse;
  logic [SEL_W-1:0] sel_s;
  logic [FTW_W-1:0] sel_word;

  ftw_sync #(.W(1), .STAGES(SYNC_N)) u_upd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(update_i), .q_o(upd_lvl)
  );

  ftw_edge u_upd_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(upd_lvl), .pulse_o(upd_pulse)
  );

  ftw_sync #(.W(SEL_W), .STAGES(SYNC_N)) u_sel_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(prof_sel_i), .q_o(sel_s)
  );

  ftw_bank #(.N(NPROF), .W(FTW_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_sel_i(sel_s), .rd_word_o(sel_word)
  );

  ftw_active #(.W(FTW_W)) u_active (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .single_tone_i(single_tone_i), .upd_pulse_i(upd_pulse),
    .sel_word_i(sel_word), .ftw_o(ftw_o), .restart_o(restart_o)
  );

  p_restart_needs_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(upd_lvl) && $past(single_tone_i));
endmodule

// File: tb/ftw_profile_ctrl_test.sv
`timescale 1ns/1ps
module ftw_profile_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        single_tone_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  prof_sel_i = '0;
  logic        update_i = 1'b0;
  logic [31:0] ftw_o;
  logic        restart_o;

  int total = 0;
  int bad = 0;

  localparam logic [31:0] A0 = 32'h1111_0000, A1 = 32'h2222_0001,
                          A2 = 32'h3333_0002, A3 = 32'h4444_0003,
                          B2 = 32'h5555_00B2;

  always #2.5 clk_i = ~clk_i;

  ftw_profile_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .single_tone_i(single_tone_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .prof_sel_i(prof_sel_i), .update_i(update_i),
    .ftw_o(ftw_o), .restart_o(restart_o)
  );

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 ftw", ftw_o, 32'h0);
    chk("R1 restart", {31'b0, restart_o}, 32'h0);
    rst_ni = 1'b1;
    tick();
    chk("R1 after release", ftw_o, 32'h0);
  endtask

  task automatic t_direct();
    single_tone_i = 1'b0;
    wr(2'd0, A0);
    chk("R8 not yet", ftw_o, 32'h0);
    tick();
    chk("R8 shown", ftw_o, A0);
    wr(2'd1, A1); wr(2'd2, A2); wr(2'd3, A3);
    tick();
    chk("R2 others untouched", ftw_o, A0);
    prof_sel_i = 2'd2;
    tick(); tick();
    chk("R7 old before third edge", ftw_o, A0);
    tick();
    chk("R7 R9 sel2", ftw_o, A2);
    update_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R7 no restart", {31'b0, restart_o}, 32'h0);
      chk("R7 update ignored", ftw_o, A2);
    end
    update_i = 1'b0;
    repeat (3) tick();
  endtask

  task automatic t_single();
    single_tone_i = 1'b1;
    tick();
    wr(2'd2, B2);
    repeat (3) tick();
    chk("R3 write held", ftw_o, A2);
    prof_sel_i = 2'd1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R4 sel held", ftw_o, A2);
      chk("R4 no restart", {31'b0, restart_o}, 32'h0);
    end
    update_i = 1'b1;
    tick(); tick();
    chk("R5 old before third edge", ftw_o, A2);
    chk("R5 restart not yet", {31'b0, restart_o}, 32'h0);
    tick();
    chk("R5 R9 loaded sel1", ftw_o, A1);
    chk("R5 restart", {31'b0, restart_o}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R6 one pulse", {31'b0, restart_o}, 32'h0);
    end
    update_i = 1'b0;
    repeat (3) tick();
    prof_sel_i = 2'd3; update_i = 1'b1;
    tick(); tick(); tick();
    chk("R9 sel3 with update", ftw_o, A3);
    chk("R6 second pulse", {31'b0, restart_o}, 32'h1);
    update_i = 1'b0;
    repeat (3) tick();
    prof_sel_i = 2'd2; update_i = 1'b1;
    repeat (3) tick();
    chk("R3 rewritten word loads", ftw_o, B2);
    update_i = 1'b0;
    tick();
    chk("R6 pulse ends", {31'b0, restart_o}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_single();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule